// File: doc/BRIEF.md
# Droop-Correcting Half-Rate FIR Decimator

This block is the last rate-halving stage of a complex receive chain. It sits behind a CIC decimator that runs at twice the final rate. It takes I/Q sample pairs at roughly 24 kHz and runs them through a 64-tap low-pass FIR. That FIR flattens the passband droop of the CIC stage in front of it and attenuates everything outside ±6 kHz, so that images folded back by the rate change stay near −50 dB or below. Only every second filtered sample is kept, giving about 12 kHz out. The filter result is computed only for the samples that are kept.

The system clock is far faster than the sample rate. Each kept output is therefore produced by a time-shared multiply-accumulate that walks a 64-entry circular history per channel. One coefficient memory serves both channels. A parameter chooses the arithmetic layout. One variant gives each channel its own multiplier and takes 64 cycles per output. The other pushes I and then Q through a single multiplier and takes 128 cycles per output. Coefficients are signed fixed-point values with CW−1 fraction bits. They can be rewritten through a simple write port whenever the filter is not computing.

Top module: `cic_comp_decim`

## Requirements
- R1: After reset, out_valid is low and out_i/out_q are zero. The history holds zeros. The coefficient memory holds 0 everywhere except tap TAPS/2, which holds 2^(CW-1)-1, so a constant input passes through unchanged after the history fills.
- R2: The inputs captured with in_valid are numbered from 0 after reset. Input number n produces an output only when n is odd. Each such input yields exactly one single-cycle out_valid pulse, and even-numbered inputs yield none.
- R3: The output for kept input n is the sum over k=0..TAPS-1 of c[k]·x[n-k], with x at negative indices taken as 0. This sum is computed separately for I and for Q with a shared coefficient set. The accumulator is wide enough that no sum of TAPS full-scale products wraps.
- R4: The sum is rounded by adding 2^(CW-2) and shifting right arithmetically by CW-1 bits.
- R5: The rounded value is clamped symmetrically to ±(2^(OW-1)-1). The code -2^(OW-1) never appears on an output.
- R6: A write with coef_we high, while the filter is not computing, stores coef_data into tap coef_addr. Tap k multiplies x[n-k]. The new value is used from the next computed output on.
- R7: A coefficient write issued while an output is being computed is dropped. Later outputs show the old tap value.
- R8: out_valid rises exactly NCYC clock edges after the edge that captured the kept input. NCYC is TAPS when SHARED_MAC=0 and 2·TAPS when SHARED_MAC=1. Both variants give identical output values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: in_i/in_q carry a new input sample |
| in_i | input | DW | In-phase input sample, signed |
| in_q | input | DW | Quadrature input sample, signed |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | log2(TAPS) | Tap index to write |
| coef_data | input | CW | Coefficient value, signed, CW-1 fraction bits |
| out_valid | output | 1 | One-cycle strobe for a new output sample |
| out_i | output | OW | In-phase output, signed |
| out_q | output | OW | Quadrature output, signed |

## Verification
The stimulus sequence is as follows:
- A constant input under the reset coefficients shows the pass-through default and checks the tap order.
- Impulses placed on even and on odd input indices, under a loaded ramp of coefficients, must bring out the odd-indexed and the even-indexed taps in order. This separates correct decimation phase and history addressing from an off-by-one in either.
- A pseudo-random stretch exercises the full convolution on I and Q at once with a shared coefficient set.
- Full-scale inputs against all-maximum and all-minimum coefficients drive the accumulator to its largest sums. This distinguishes symmetric saturation from wrap-around or asymmetric clipping.
- A coefficient written mid-computation and then again while idle shows whether the write guard and the timing of the update are right.

Both the dedicated-multiplier and the shared-multiplier variants run the same sequence against one arithmetic model, and their output latency is checked too.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

   typedef enum logic [0:0] {
      LANE_I = 1'b0,
      LANE_Q = 1'b1
   } lane_e;

   localparam int NUM_LANES = 2;

   // clock cycles spent computing one retained output
   function automatic int cycles_per_output(input int taps, input int shared_mac);
      return (shared_mac != 0) ? taps * NUM_LANES : taps;
   endfunction

endpackage

// File: rtl/cdec_sample_buf.sv
module cdec_sample_buf #(
   parameter int DEPTH = 64,
   parameter int DW    = 16,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [PW-1:0]        waddr,
   input  logic signed [DW-1:0] wdata,
   input  logic [PW-1:0]        raddr,
   output logic signed [DW-1:0] rdata
);

   logic signed [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/cdec_coef_bank.sv
module cdec_coef_bank #(
   parameter int TAPS = 64,
   parameter int CW   = 18,
   localparam int TW  = $clog2(TAPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [TW-1:0]        waddr,
   input  logic signed [CW-1:0] wdata,
   input  logic [TW-1:0]        raddr,
   output logic signed [CW-1:0] rdata
);

   localparam int                   UNITY_TAP = TAPS / 2;
   localparam logic signed [CW-1:0] UNITY_VAL = {1'b0, {(CW-1){1'b1}}};

   logic signed [CW-1:0] mem [TAPS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < TAPS; k++) mem[k] <= (k == UNITY_TAP) ? UNITY_VAL : '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/cdec_mac.sv
module cdec_mac #(
   parameter int DW = 16,
   parameter int CW = 18,
   parameter int AW = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 clr,
   input  logic signed [DW-1:0] x,
   input  logic signed [CW-1:0] c,
   output logic signed [AW-1:0] sum_o
);

   localparam int PW = DW + CW;

   logic signed [PW-1:0] prod;
   logic signed [AW-1:0] prod_ext;
   logic signed [AW-1:0] acc_q;

   assign prod     = x * c;
   assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
   assign sum_o    = (clr ? '0 : acc_q) + prod_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc_q <= '0;
      else if (en) acc_q <= sum_o;
   end

endmodule

// File: rtl/cdec_round_sat.sv
module cdec_round_sat #(
   parameter int IW   = 40,
   parameter int FRAC = 17,
   parameter int OW   = 16
) (
   input  logic signed [IW-1:0] din,
   output logic signed [OW-1:0] dout
);

   localparam logic signed [IW:0] HALF = {{(IW+1-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
   localparam logic signed [IW:0] HI   = {{(IW+2-OW){1'b0}}, {(OW-1){1'b1}}};
   localparam logic signed [IW:0] LO   = -HI;

   logic signed [IW:0] biased;
   logic signed [IW:0] shifted;

   assign biased  = {din[IW-1], din} + HALF;
   assign shifted = biased >>> FRAC;

   always_comb begin
      if (shifted > HI)      dout = HI[OW-1:0];
      else if (shifted < LO) dout = LO[OW-1:0];
      else                   dout = shifted[OW-1:0];
   end

endmodule

// File: rtl/cic_comp_decim.sv
module cic_comp_decim #(
   parameter int TAPS       = 64,
   parameter int DW         = 16,
   parameter int CW         = 18,
   parameter int OW         = 16,
   parameter int SHARED_MAC = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [DW-1:0]        in_i,
   input  logic [DW-1:0]        in_q,
   input  logic                 coef_we,
   input  logic [$clog2(TAPS)-1:0] coef_addr,
   input  logic [CW-1:0]        coef_data,
   output logic                 out_valid,
   output logic [OW-1:0]        out_i,
   output logic [OW-1:0]        out_q
);
   import cdec_pkg::*;

   localparam int TW   = $clog2(TAPS);
   localparam int NCYC = cycles_per_output(TAPS, SHARED_MAC);
   localparam int CNTW = $clog2(NCYC);
   localparam int AW   = DW + CW + TW;
   localparam int FRAC = CW - 1;
   localparam int NMAC = (SHARED_MAC != 0) ? 1 : NUM_LANES;

   initial begin
      assert_param_taps_R3: assert (TAPS >= 4 && (TAPS & (TAPS - 1)) == 0)
         else $error("TAPS must be a power of two of at least 4");
      assert_param_coef_R4: assert (CW >= 4)
         else $error("CW too small");
      assert_param_out_R5: assert (OW >= 2 && OW <= 31 && OW <= DW + CW)
         else $error("OW out of range");
      assert_param_mode_R8: assert (SHARED_MAC == 0 || SHARED_MAC == 1)
         else $error("SHARED_MAC must be 0 or 1");
   end

   // sequencing state
   logic            ph_q;
   logic [TW-1:0]   wp_q;
   logic [TW-1:0]   newest_q;
   logic            run_q;
   logic [CNTW-1:0] cnt_q;
   logic            last;
   logic [TW-1:0]   tap;
   logic [TW-1:0]   raddr;
   logic            tap_first;

   assign last      = (cnt_q == CNTW'(NCYC - 1));
   assign tap       = cnt_q[TW-1:0];
   assign tap_first = (tap == '0);
   assign raddr     = newest_q - tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= 1'b0;
         wp_q     <= '0;
         newest_q <= '0;
         run_q    <= 1'b0;
         cnt_q    <= '0;
      end else begin
         if (run_q) begin
            cnt_q <= cnt_q + CNTW'(1);
            if (last) run_q <= 1'b0;
         end
         if (in_valid) begin
            wp_q     <= wp_q + TW'(1);
            newest_q <= wp_q;
            ph_q     <= ~ph_q;
            if (ph_q) begin
               run_q <= 1'b1;
               cnt_q <= '0;
            end
         end
      end
   end

   // coefficient memory, written only while idle
   logic signed [CW-1:0] coef_rd;

   cdec_coef_bank #(.TAPS(TAPS), .CW(CW)) coef_bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (coef_we & ~run_q),
      .waddr (coef_addr),
      .wdata (coef_data),
      .raddr (tap),
      .rdata (coef_rd)
   );

   // per-channel sample history
   logic signed [DW-1:0] samp [NUM_LANES];

   for (genvar ch = 0; ch < NUM_LANES; ch++) begin : g_hist
      cdec_sample_buf #(.DEPTH(TAPS), .DW(DW)) hist_i (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (in_valid),
         .waddr (wp_q),
         .wdata ((ch == 0) ? in_i : in_q),
         .raddr (raddr),
         .rdata (samp[ch])
      );
   end

   logic signed [AW-1:0] mac_sum [NMAC];
   logic signed [OW-1:0] rnd     [NMAC];
   logic                 ov_q;

   for (genvar m = 0; m < NMAC; m++) begin : g_round
      cdec_round_sat #(.IW(AW), .FRAC(FRAC), .OW(OW)) round_i (
         .din  (mac_sum[m]),
         .dout (rnd[m])
      );
   end

   if (SHARED_MAC == 0) begin : g_dual
      for (genvar m = 0; m < NMAC; m++) begin : g_lane
         cdec_mac #(.DW(DW), .CW(CW), .AW(AW)) mac_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (run_q),
            .clr   (tap_first),
            .x     (samp[m]),
            .c     (coef_rd),
            .sum_o (mac_sum[m])
         );
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_i <= '0;
            out_q <= '0;
         end else if (run_q && last) begin
            out_i <= rnd[LANE_I];
            out_q <= rnd[LANE_Q];
         end
      end
   end else begin : g_shared
      lane_e                lane;
      logic signed [DW-1:0] x_sel;
      logic signed [OW-1:0] hold_i_q;

      assign lane  = lane_e'(cnt_q[TW]);
      assign x_sel = (lane == LANE_Q) ? samp[LANE_Q] : samp[LANE_I];

      cdec_mac #(.DW(DW), .CW(CW), .AW(AW)) mac_i (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (run_q),
         .clr   (tap_first),
         .x     (x_sel),
         .c     (coef_rd),
         .sum_o (mac_sum[0])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_i_q <= '0;
            out_i    <= '0;
            out_q    <= '0;
         end else if (run_q) begin
            if (lane == LANE_I && tap == TW'(TAPS - 1)) hold_i_q <= rnd[0];
            if (last) begin
               out_i <= hold_i_q;
               out_q <= rnd[0];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ov_q <= 1'b0;
      else        ov_q <= run_q && last;
   end

   assign out_valid = ov_q;

endmodule

// File: rtl/cdec_checker.sv
module cdec_checker #(
   parameter int NCYC = 64,
   parameter int OW   = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          busy,
   input logic          out_valid,
   input logic [OW-1:0] out_i,
   input logic [OW-1:0] out_q
);

   localparam int          LW     = $clog2(NCYC + 1) + 1;
   localparam logic [OW-1:0] NEG_FS = {1'b1, {(OW-1){1'b0}}};

   logic [LW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + LW'(1);
      else           run_len <= '0;
   end

   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_start_on_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(in_valid));

   assert_symmetric_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_i != NEG_FS && out_q != NEG_FS));

   assert_run_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == LW'(NCYC)));

   assert_result_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> out_valid);

endmodule

bind cic_comp_decim cdec_checker #(.NCYC(NCYC), .OW(OW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .busy      (run_q),
   .out_valid (out_valid),
   .out_i     (out_i),
   .out_q     (out_q)
);

// File: tb/cic_comp_decim_tb_top.sv
module cic_comp_decim_tb_top;

   localparam int TAPS = 64;
   localparam int DW   = 16;
   localparam int CW   = 18;
   localparam int OW   = 16;
   localparam int TW   = $clog2(TAPS);
   localparam int GAP  = 135;
   localparam int MAXN = 1024;
   localparam longint OMAX = (64'sd1 <<< (OW - 1)) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [DW-1:0] in_i = '0, in_q = '0;
   logic coef_we = 1'b0;
   logic [TW-1:0] coef_addr = '0;
   logic [CW-1:0] coef_data = '0;

   logic          ov0, ov1;
   logic [OW-1:0] oi0, oq0, oi1, oq1;

   always #5 clk = ~clk;

   cic_comp_decim #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW), .SHARED_MAC(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
      .out_valid(ov0), .out_i(oi0), .out_q(oq0));

   cic_comp_decim #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW), .SHARED_MAC(1)) dut_shared_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
      .out_valid(ov1), .out_i(oi1), .out_q(oq1));

   int     nchk = 0, nfail = 0;
   longint cyc = 0;
   longint coef [TAPS];
   longint hist_i [MAXN];
   longint hist_q [MAXN];
   int     n = 0;
   longint exp_i = 0, exp_q = 0, t0 = 0;
   bit     pend = 0, got0 = 0, got1 = 0, done = 0;
   logic [15:0] lfsr = 16'hACE1;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // arithmetic model of R3, R4, R5
   function automatic longint model(input bit q, input int idx);
      longint acc = 0;
      longint r;
      for (int k = 0; k < TAPS; k++)
         if (idx - k >= 0) acc += coef[k] * (q ? hist_q[idx - k] : hist_i[idx - k]);
      r = (acc + (64'sd1 <<< (CW - 2))) >>> (CW - 1);
      if (r > OMAX) r = OMAX;
      if (r < -OMAX) r = -OMAX;
      return r;
   endfunction

   always @(negedge clk) begin
      if (rst_n && ov0) begin
         if (!pend || got0) chk("R2 unexpected pulse dual", 1, 0);
         else begin
            got0 = 1;
            chk("R3 out_i dual", longint'($signed(oi0)), exp_i);
            chk("R3 out_q dual", longint'($signed(oq0)), exp_q);
            chk("R8 latency dual", cyc - t0, TAPS);
         end
      end
      if (rst_n && ov1) begin
         if (!pend || got1) chk("R2 unexpected pulse shared", 1, 0);
         else begin
            got1 = 1;
            chk("R8 out_i shared", longint'($signed(oi1)), exp_i);
            chk("R8 out_q shared", longint'($signed(oq1)), exp_q);
            chk("R8 latency shared", cyc - t0, 2 * TAPS);
         end
      end
   end

   task automatic close_pending();
      if (pend) begin
         chk("R2 output present dual", longint'(got0), 1);
         chk("R2 output present shared", longint'(got1), 1);
         pend = 0;
      end
   endtask

   task automatic send(input int si, input int sq, input bit bw, input int ba, input int bd);
      close_pending();
      @(negedge clk);
      in_valid = 1'b1;
      in_i = si[DW-1:0];
      in_q = sq[DW-1:0];
      hist_i[n] = si;
      hist_q[n] = sq;
      if (n % 2 == 1) begin
         exp_i = model(0, n);
         exp_q = model(1, n);
         got0 = 0;
         got1 = 0;
         pend = 1;
      end
      n++;
      @(negedge clk);
      in_valid = 1'b0;
      t0 = cyc;
      if (bw) begin
         // R7: write during the computation, model left unchanged
         repeat (4) @(negedge clk);
         coef_we = 1'b1;
         coef_addr = ba[TW-1:0];
         coef_data = bd[CW-1:0];
         @(negedge clk);
         coef_we = 1'b0;
      end
      repeat (GAP) @(negedge clk);
   endtask

   task automatic put(input int si, input int sq);
      send(si, sq, 0, 0, 0);
   endtask

   task automatic wr_coef(input int a, input int d);
      @(negedge clk);
      coef_we = 1'b1;
      coef_addr = a[TW-1:0];
      coef_data = d[CW-1:0];
      @(negedge clk);
      coef_we = 1'b0;
      coef[a] = d;
   endtask

   task automatic zeros(input int cnt);
      for (int z = 0; z < cnt; z++) put(0, 0);
   endtask

   task automatic align_even();
      if (n % 2 == 1) put(0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < TAPS; k++) coef[k] = (k == TAPS / 2) ? (64'sd1 <<< (CW - 1)) - 1 : 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 out_valid dual", longint'(ov0), 0);
      chk("R1 out_i dual", longint'(oi0), 0);
      chk("R1 out_q dual", longint'(oq0), 0);
      chk("R1 out_valid shared", longint'(ov1), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: default taps pass a constant through after the history fills
      for (int s = 0; s < 70; s++) put(1000, -3000);
      chk("R1 pass-through I", exp_i, 1000);
      chk("R1 pass-through Q", exp_q, -3000);

      // R6: load a ramp of taps while idle
      for (int k = 0; k < TAPS; k++) wr_coef(k, (k - 31) * 4000 + (k % 3) * 17);
      zeros(64);
      align_even();
      // R3: impulse on an even index brings out odd taps
      put(32767, -32768);
      zeros(65);
      align_even();
      // R3: impulse on an odd index brings out even taps
      put(0, 0);
      put(-20000, 12345);
      zeros(65);

      // R3: pseudo-random stretch on both channels
      for (int s = 0; s < 100; s++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         put(int'($signed(lfsr)), int'($signed({lfsr[7:0], lfsr[15:8]})));
      end

      // R7: write while busy is dropped
      align_even();
      put(0, 0);
      send(5000, -7000, 1, 5, 99999);
      for (int s = 0; s < 10; s++) put(3000 - s * 500, s * 400);
      // R6: same write while idle takes effect
      wr_coef(5, 99999);
      for (int s = 0; s < 10; s++) put(3000 - s * 500, s * 400);

      // R5: saturation with maximum taps, full-scale inputs of both signs
      for (int k = 0; k < TAPS; k++) wr_coef(k, (1 <<< (CW - 1)) - 1);
      for (int s = 0; s < 66; s++) put(32767, -32768);
      chk("R5 positive clip", exp_i, OMAX);
      chk("R5 negative clip symmetric", exp_q, -OMAX);
      // R3: largest accumulator sums do not wrap
      for (int k = 0; k < TAPS; k++) wr_coef(k, -(1 <<< (CW - 1)));
      for (int s = 0; s < 66; s++) put(-32768, 32767);
      chk("R3 no wrap I", exp_i, OMAX);
      chk("R3 no wrap Q", exp_q, -OMAX);

      close_pending();
      repeat (20) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule